// File: doc/BRIEF.md
# Virtual Interrupt Acknowledge Unit

This block serves an acknowledge read from a virtual processor. It receives a small array of list entries that describe virtual interrupts. Each entry carries a two-bit state, an eight-bit priority, a group bit and a virtual interrupt ID. When the block gets a request for group 0 or group 1, it scans the entries that are in use. It picks the pending entry with the best priority among those whose group is enabled. It then tests that winner against the requested group, the priority mask and the running priority. The running-priority test compares against the winner's preemption level, which is the priority with its subpriority bits cleared according to the binary point of the group.

When every test passes, the block issues three outputs. It writes back a new state for the winning entry. It asks the active-priority tracker to mark the preemption level active for the group. It returns the virtual ID. Otherwise it returns the spurious ID 1023 and leaves the entries and the tracker untouched. The answer comes exactly one clock after the request. The environment must apply the write-back before it issues the next request.

Top module: `virq_ack_unit`

## Requirements
- R1: After reset, `rsp_valid`, `wb_valid` and `ap_valid` are 0 and `rsp_id` is 1023.
- R2: A request sampled at a rising edge produces a one-cycle `rsp_valid` pulse after that edge. `rsp_id` then holds its value until the next request.
- R3: An entry is a candidate only if all three hold: its index is below `used_cnt`, its state is exactly 2'b01 (bit 0 pending, bit 1 active), and the enable of its group (`ent_grp` 0 or 1) is set.
- R4: The winner is the candidate with the numerically lowest priority. When priorities are equal, the lowest index wins.
- R5: The response is 1023 when there is no candidate, or when the winner's group differs from `req_grp`.
- R6: The response is 1023 when `pmr` is less than or equal to the winner's priority.
- R7: The preemption level is the priority with its low bits cleared. The number of cleared bits is `bpr0`+1 for group 0 and `bpr1` for group 1. The response is 1023 when `run_prio` is less than or equal to that level.
- R8: On success, `wb_valid` pulses with `wb_idx` set to the winner's index. `wb_state` is 2'b10 (active) when the ID is at most 1019, and 2'b00 otherwise.
- R9: On success, `rsp_id` is the winner's virtual ID. `ap_valid` pulses with `ap_grp` equal to `req_grp` and `ap_level` equal to the preemption level.
- R10: When the response is spurious, neither `wb_valid` nor `ap_valid` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Acknowledge request |
| req_grp | input | 1 | Requested group (0 or 1) |
| used_cnt | input | CNT_W | Number of entries in use |
| grp0_en | input | 1 | Group 0 enable |
| grp1_en | input | 1 | Group 1 enable |
| pmr | input | 8 | Priority mask |
| run_prio | input | 8 | Current running priority |
| bpr0 | input | 3 | Group 0 binary point |
| bpr1 | input | 3 | Group 1 binary point |
| ent_state | input | 2*N | Entry states, two bits per entry |
| ent_prio | input | 8*N | Entry priorities |
| ent_grp | input | N | Entry group bits |
| ent_vid | input | ID_W*N | Entry virtual IDs |
| rsp_valid | output | 1 | Response pulse |
| rsp_id | output | ID_W | Returned ID, held until the next request |
| wb_valid | output | 1 | Entry write-back pulse |
| wb_idx | output | IDX_W | Index of the entry to rewrite |
| wb_state | output | 2 | New state of that entry |
| ap_valid | output | 1 | Active-priority set pulse |
| ap_grp | output | 1 | Group for the active-priority set |
| ap_level | output | 8 | Preemption level to mark active |

## Verification
The hardest cases to reach are the ones where a nearly correct scan would still pick the same ID. Examples are an equal-priority pair, an entry that is pending and active at once with the best priority, and an entry beyond the used count. The bench therefore loads one fixed entry set that contains all of these traps. It then walks a vector table that changes only the used count, the enables, the mask, the running priority and the binary points. The running-priority and mask values sit exactly at the winner's priority or level, and one step above it, so both sides of each comparison are exercised. A non-zero binary point makes the preemption level differ from the raw priority.

// File: rtl/virq_pkg.sv
package virq_pkg;
  localparam int          PRI_W       = 8;
  localparam logic [7:0]  IDLE_PRI    = 8'hFF;
  localparam int          SPURIOUS_ID = 1023;
  localparam int          SPI_MAX     = 1019;
  localparam logic [1:0]  ST_NONE     = 2'b00;
  localparam logic [1:0]  ST_PEND     = 2'b01;
  localparam logic [1:0]  ST_ACT      = 2'b10;
endpackage

// File: rtl/virq_scan.sv
module virq_scan
  import virq_pkg::*;
#(
  parameter int N     = 16,
  parameter int ID_W  = 16,
  parameter int CNT_W = $clog2(N + 1),
  parameter int IDX_W = $clog2(N)
) (
  input  logic [CNT_W-1:0]  used_cnt,
  input  logic              grp0_en,
  input  logic              grp1_en,
  input  logic [2*N-1:0]    ent_state,
  input  logic [8*N-1:0]    ent_prio,
  input  logic [N-1:0]      ent_grp,
  input  logic [ID_W*N-1:0] ent_vid,
  output logic              found,
  output logic [IDX_W-1:0]  win_idx,
  output logic [7:0]        win_pri,
  output logic              win_grp,
  output logic [ID_W-1:0]   win_vid
);
  logic [7:0]       best_pri [N+1];
  logic [IDX_W-1:0] best_idx [N+1];
  logic             best_ok  [N+1];

  assign best_pri[0] = IDLE_PRI;
  assign best_idx[0] = '0;
  assign best_ok[0]  = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic [7:0] pri;
    logic       cand;
    logic       take;
    assign pri  = ent_prio[8*g +: 8];
    assign cand = (CNT_W'(g) < used_cnt) &&
                  (ent_state[2*g +: 2] == ST_PEND) &&
                  (ent_grp[g] ? grp1_en : grp0_en);
    assign take = cand && (pri < best_pri[g]);
    assign best_pri[g+1] = take ? pri : best_pri[g];
    assign best_idx[g+1] = take ? IDX_W'(g) : best_idx[g];
    assign best_ok[g+1]  = take | best_ok[g];
  end

  assign found   = best_ok[N];
  assign win_idx = best_idx[N];
  assign win_pri = best_pri[N];
  assign win_grp = ent_grp[win_idx];
  assign win_vid = ent_vid[ID_W*win_idx +: ID_W];
endmodule

// File: rtl/virq_gate.sv
module virq_gate
  import virq_pkg::*;
#(
  parameter int ID_W = 16
) (
  input  logic            found,
  input  logic [7:0]      win_pri,
  input  logic            win_grp,
  input  logic [ID_W-1:0] win_vid,
  input  logic            req_grp,
  input  logic [7:0]      pmr,
  input  logic [7:0]      run_prio,
  input  logic [2:0]      bpr0,
  input  logic [2:0]      bpr1,
  output logic            grant,
  output logic [7:0]      level,
  output logic [1:0]      next_state
);
  logic [3:0] sub_bits;
  logic [7:0] pre_mask;

  always_comb begin
    if (req_grp) sub_bits = {1'b0, bpr1};
    else         sub_bits = {1'b0, bpr0} + 4'd1;
    pre_mask = 8'hFF << sub_bits;
    level    = win_pri & pre_mask;
    grant    = found && (win_grp == req_grp) &&
               (pmr > win_pri) && (run_prio > level);
    next_state = (win_vid <= ID_W'(SPI_MAX)) ? ST_ACT : ST_NONE;
  end
endmodule

// File: rtl/virq_ack_unit.sv
module virq_ack_unit
  import virq_pkg::*;
#(
  parameter int N     = 16,
  parameter int ID_W  = 16,
  parameter int CNT_W = $clog2(N + 1),
  parameter int IDX_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_grp,
  input  logic [CNT_W-1:0]  used_cnt,
  input  logic              grp0_en,
  input  logic              grp1_en,
  input  logic [7:0]        pmr,
  input  logic [7:0]        run_prio,
  input  logic [2:0]        bpr0,
  input  logic [2:0]        bpr1,
  input  logic [2*N-1:0]    ent_state,
  input  logic [8*N-1:0]    ent_prio,
  input  logic [N-1:0]      ent_grp,
  input  logic [ID_W*N-1:0] ent_vid,
  output logic              rsp_valid,
  output logic [ID_W-1:0]   rsp_id,
  output logic              wb_valid,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [1:0]        wb_state,
  output logic              ap_valid,
  output logic              ap_grp,
  output logic [7:0]        ap_level
);
  logic             found, win_grp, grant;
  logic [IDX_W-1:0] win_idx;
  logic [7:0]       win_pri, level;
  logic [ID_W-1:0]  win_vid;
  logic [1:0]       next_state;

  virq_scan #(.N(N), .ID_W(ID_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_scan (
    .used_cnt(used_cnt), .grp0_en(grp0_en), .grp1_en(grp1_en),
    .ent_state(ent_state), .ent_prio(ent_prio), .ent_grp(ent_grp),
    .ent_vid(ent_vid), .found(found), .win_idx(win_idx),
    .win_pri(win_pri), .win_grp(win_grp), .win_vid(win_vid)
  );

  virq_gate #(.ID_W(ID_W)) u_gate (
    .found(found), .win_pri(win_pri), .win_grp(win_grp), .win_vid(win_vid),
    .req_grp(req_grp), .pmr(pmr), .run_prio(run_prio),
    .bpr0(bpr0), .bpr1(bpr1), .grant(grant), .level(level),
    .next_state(next_state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_id    <= ID_W'(SPURIOUS_ID);
      wb_valid  <= 1'b0;
      wb_idx    <= '0;
      wb_state  <= ST_NONE;
      ap_valid  <= 1'b0;
      ap_grp    <= 1'b0;
      ap_level  <= IDLE_PRI;
    end else begin
      rsp_valid <= req;
      wb_valid  <= req && grant;
      ap_valid  <= req && grant;
      if (req) begin
        rsp_id   <= grant ? win_vid : ID_W'(SPURIOUS_ID);
        wb_idx   <= win_idx;
        wb_state <= next_state;
        ap_grp   <= req_grp;
        ap_level <= level;
      end
    end
  end
endmodule

// File: rtl/virq_ack_unit_chk.sv
module virq_ack_unit_chk #(
  parameter int ID_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            req,
  input logic            req_grp,
  input logic [7:0]      run_prio,
  input logic            rsp_valid,
  input logic [ID_W-1:0] rsp_id,
  input logic            wb_valid,
  input logic [1:0]      wb_state,
  input logic            ap_valid,
  input logic            ap_grp,
  input logic [7:0]      ap_level
);
  a_r2_resp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req |=> rsp_valid);
  a_r2_id_held: assert property (@(posedge clk) disable iff (rst)
    !req |=> $stable(rsp_id));
  a_r10_spurious_quiet: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_id == ID_W'(1023)) |-> (!wb_valid && !ap_valid));
  a_r8_active_for_spi: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && rsp_id <= ID_W'(1019)) |-> (wb_state == 2'b10));
  a_r8_idle_for_msg: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && rsp_id > ID_W'(1019)) |-> (wb_state == 2'b00));
  a_r7_level_below_run: assert property (@(posedge clk) disable iff (rst)
    ap_valid |-> (ap_level < $past(run_prio)));
  a_r9_group_matches: assert property (@(posedge clk) disable iff (rst)
    ap_valid |-> (ap_grp == $past(req_grp) && wb_valid && rsp_valid));
endmodule

bind virq_ack_unit virq_ack_unit_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rst(rst), .req(req), .req_grp(req_grp), .run_prio(run_prio),
  .rsp_valid(rsp_valid), .rsp_id(rsp_id), .wb_valid(wb_valid),
  .wb_state(wb_state), .ap_valid(ap_valid), .ap_grp(ap_grp),
  .ap_level(ap_level)
);

// File: tb/virq_ack_unit_bench.sv
module virq_ack_unit_bench;
  localparam int N = 16, ID_W = 16, CNT_W = 5, IDX_W = 4;

  typedef struct packed {
    logic [4:0] used;
    logic       en0, en1, grp;
    logic [7:0] pmr, run;
    logic [2:0] b0, b1;
    logic       ok;
    logic [15:0] id;
    logic [3:0] idx;
    logic [1:0] st;
    logic [7:0] lvl;
  } vec_t;

  // used en0 en1 grp pmr run b0 b1 | ok id idx st lvl
  localparam vec_t VEC [14] = '{
    '{16, 1, 1, 1, 8'hFF, 8'hFF, 0, 0, 1, 2000, 6, 2'b00, 8'h20}, // R3 R4 R8: skips 11/10 states, ID>1019
    '{ 6, 1, 1, 1, 8'hFF, 8'hFF, 0, 0, 0, 1023, 0, 2'b00, 8'h00}, // R5 group mismatch
    '{ 6, 0, 1, 1, 8'hFF, 8'hFF, 0, 0, 1,  103, 3, 2'b10, 8'h30}, // R4 tie, lower index
    '{ 6, 0, 1, 1, 8'h30, 8'hFF, 0, 0, 0, 1023, 0, 2'b00, 8'h00}, // R6 mask equal
    '{ 6, 0, 1, 1, 8'h31, 8'hFF, 0, 0, 1,  103, 3, 2'b10, 8'h30}, // R6 mask above
    '{ 6, 0, 1, 1, 8'hFF, 8'h30, 0, 0, 0, 1023, 0, 2'b00, 8'h00}, // R7 run equal
    '{ 6, 0, 1, 1, 8'hFF, 8'h31, 0, 0, 1,  103, 3, 2'b10, 8'h30}, // R7 run above
    '{ 6, 0, 1, 1, 8'hFF, 8'h21, 0, 5, 1,  103, 3, 2'b10, 8'h20}, // R7 R9 group 1 binary point
    '{ 6, 0, 1, 1, 8'hFF, 8'h20, 0, 5, 0, 1023, 0, 2'b00, 8'h00}, // R7 level equal
    '{ 6, 1, 0, 0, 8'hFF, 8'h21, 4, 0, 1,   32, 2, 2'b10, 8'h20}, // R7 R9 group 0 bpr0+1
    '{ 6, 1, 0, 0, 8'hFF, 8'h20, 4, 0, 0, 1023, 0, 2'b00, 8'h00}, // R7 group 0 equal
    '{ 6, 0, 0, 1, 8'hFF, 8'hFF, 0, 0, 0, 1023, 0, 2'b00, 8'h00}, // R3 R5 both disabled
    '{ 0, 1, 1, 1, 8'hFF, 8'hFF, 0, 0, 0, 1023, 0, 2'b00, 8'h00}, // R3 none used
    '{ 1, 1, 1, 1, 8'hFF, 8'hFF, 0, 0, 1,  100, 0, 2'b10, 8'h40}  // R3 only first used
  };

  logic clk = 0, rst = 1, req = 0, req_grp = 0, grp0_en = 0, grp1_en = 0;
  logic [CNT_W-1:0] used_cnt = '0;
  logic [7:0] pmr = 0, run_prio = 0;
  logic [2:0] bpr0 = 0, bpr1 = 0;
  logic [2*N-1:0] ent_state = '0;
  logic [8*N-1:0] ent_prio = '0;
  logic [N-1:0] ent_grp = '0;
  logic [ID_W*N-1:0] ent_vid = '0;
  logic rsp_valid, wb_valid, ap_valid, ap_grp;
  logic [ID_W-1:0] rsp_id;
  logic [IDX_W-1:0] wb_idx;
  logic [1:0] wb_state;
  logic [7:0] ap_level;
  int checks = 0, errors = 0;
  logic done = 0;

  always #10 clk = ~clk;

  virq_ack_unit #(.N(N), .ID_W(ID_W)) u_virq_ack_unit (
    .clk(clk), .rst(rst), .req(req), .req_grp(req_grp), .used_cnt(used_cnt),
    .grp0_en(grp0_en), .grp1_en(grp1_en), .pmr(pmr), .run_prio(run_prio),
    .bpr0(bpr0), .bpr1(bpr1), .ent_state(ent_state), .ent_prio(ent_prio),
    .ent_grp(ent_grp), .ent_vid(ent_vid), .rsp_valid(rsp_valid),
    .rsp_id(rsp_id), .wb_valid(wb_valid), .wb_idx(wb_idx),
    .wb_state(wb_state), .ap_valid(ap_valid), .ap_grp(ap_grp),
    .ap_level(ap_level)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_ent(int i, logic [1:0] st, logic [7:0] p, logic g, logic [15:0] v);
    ent_state[2*i +: 2] = st;
    ent_prio[8*i +: 8]  = p;
    ent_grp[i]          = g;
    ent_vid[ID_W*i +: ID_W] = v;
  endtask

  initial begin
    set_ent(0, 2'b01, 8'h40, 1, 100);
    set_ent(1, 2'b11, 8'h10, 1, 101);
    set_ent(2, 2'b01, 8'h30, 0, 32);
    set_ent(3, 2'b01, 8'h30, 1, 103);
    set_ent(4, 2'b01, 8'h30, 1, 104);
    set_ent(5, 2'b10, 8'h00, 1, 105);
    set_ent(6, 2'b01, 8'h20, 1, 2000);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 wb_valid", wb_valid, 0);
    chk("R1 ap_valid", ap_valid, 0);
    chk("R1 rsp_id", rsp_id, 1023);
    rst = 0;
    @(negedge clk);
    chk("R2 no pulse without req", rsp_valid, 0);
    for (int v = 0; v < 14; v++) begin
      used_cnt = VEC[v].used; grp0_en = VEC[v].en0; grp1_en = VEC[v].en1;
      req_grp = VEC[v].grp; pmr = VEC[v].pmr; run_prio = VEC[v].run;
      bpr0 = VEC[v].b0; bpr1 = VEC[v].b1; req = 1;
      @(negedge clk);
      req = 0;
      chk($sformatf("R2 rsp_valid vec %0d", v), rsp_valid, 1);
      chk($sformatf("R9 rsp_id vec %0d", v), rsp_id, VEC[v].id);
      chk($sformatf("R10 wb_valid vec %0d", v), wb_valid, VEC[v].ok);
      chk($sformatf("R10 ap_valid vec %0d", v), ap_valid, VEC[v].ok);
      if (VEC[v].ok) begin
        chk($sformatf("R8 wb_idx vec %0d", v), wb_idx, VEC[v].idx);
        chk($sformatf("R8 wb_state vec %0d", v), wb_state, VEC[v].st);
        chk($sformatf("R9 ap_grp vec %0d", v), ap_grp, VEC[v].grp);
        chk($sformatf("R9 ap_level vec %0d", v), ap_level, VEC[v].lvl);
      end
    end
    // R2: result held, pulses end
    repeat (3) @(negedge clk);
    chk("R2 rsp_id held", rsp_id, 100);
    chk("R2 rsp_valid one cycle", rsp_valid, 0);
    chk("R8 wb_valid one cycle", wb_valid, 0);
    // R4: remove index 3, tie partner index 4 now wins
    set_ent(3, 2'b00, 8'h30, 1, 103);
    used_cnt = 6; grp0_en = 0; grp1_en = 1; req_grp = 1;
    pmr = 8'hFF; run_prio = 8'hFF; bpr1 = 0; req = 1;
    @(negedge clk);
    req = 0;
    chk("R4 next in tie", rsp_id, 104);
    chk("R8 next idx", wb_idx, 4);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule